// File: doc/BRIEF.md
# Barrier Flag Mirror with Selector

Each processor on a board keeps its own mirror of the barrier-busy flags held by the board's barrier units. When a flag changes, a change message is broadcast to every processor. The message names the unit, the line within that unit and the new value. This block applies each such message to its local mirror, so software never has to reach the shared flag storage to poll a barrier.

Application code reads the flags through two read ports. It cannot choose a flag directly. Instead, supervisor code programs two control registers, one for each port. Each register holds a valid bit and a select made of a unit bit and a line number. A port returns the selected mirrored flag in bit 0 of a 64-bit word. While its register is not valid, the port returns zero.

The control registers sit behind a supervisor access port with address-space and offset decode. The port reports an error pulse for misdirected or unprivileged accesses.

Top module: `barrier_mirror_sel`

## Requirements
- R1: After reset all 16 mirrored flags are 0, both control registers read as 0 with the valid bit cleared, both read ports return 0, and `reg_rdata` and `reg_err` are 0.
- R2: A broadcast update with `upd_valid` high writes `upd_value` into the single flag with index {unit, line} (unit times 8 plus line), and leaves the other 15 flags unchanged.
- R3: Control register 0 sits at address space 0x6F, offset 0x00, and governs read port 0. Control register 1 sits at address space 0x6F, offset 0x08, and governs read port 1.
- R4: While bit 63 (valid) of a control register is 0, its read port returns 0 whatever the select bits and the flags hold.
- R5: While the valid bit is 1, the read port returns, in bit 0, the mirrored flag picked by bit 3 (unit) and bits 2:0 (line) of its control register. Bits 63:1 of the port are 0.
- R6: A supervisor read of a control register places the register in `reg_rdata` one cycle after the request. Only bits 63, 3 and 2:0 can be non-zero, and they hold the values last written. Bits outside those fields are dropped on write. `reg_rdata` is 0 in every cycle that does not follow a successful read.
- R7: When a broadcast update and a port read hit the same flag in one cycle, the port shows the old value in that cycle and the new value from the next cycle on.
- R8: A supervisor access whose address space is not 0x6F, or whose offset is neither 0x00 nor 0x08, changes no state and raises `reg_err` for one cycle.
- R9: An access with `reg_priv` low, whether a read or a write, changes no control register, returns `reg_rdata` 0 and raises `reg_err` for one cycle.
- R10: `reg_err` is high exactly in the cycle after a rejected request and is 0 after accepted requests and idle cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Broadcast change message strobe |
| upd_unit | input | 1 | Barrier unit named by the message |
| upd_line | input | 3 | Barrier line within the unit |
| upd_value | input | 1 | New flag value |
| reg_req | input | 1 | Control register access request |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_priv | input | 1 | 1 = supervisor access |
| reg_aspace | input | 8 | Address space of the access |
| reg_offset | input | 8 | Offset of the access |
| reg_wdata | input | 64 | Write data |
| reg_rdata | output | 64 | Read data, one cycle after the request |
| reg_err | output | 1 | One-cycle error pulse for a rejected access |
| rd0_data | output | 64 | Application read port 0 |
| rd1_data | output | 64 | Application read port 1 |

## Verification
Each of the 16 flags is given a distinct value pattern. The select of port 0 is then walked across every index, which tells a wrong unit/line weighting or a swapped field apart from a correct mux. Selects that differ only in the unit bit, and pairs of writes that set the ports to different indices, show whether each port follows its own register. Updates are aimed at the selected flag in the same cycle as the port is observed, and at neighbouring flags, to separate the old-then-new timing from leakage between flags. Junk high bits, a wrong address space, wrong offsets and unprivileged reads and writes each show whether rejected or masked data ever reaches state.

// File: rtl/bfm_pkg.sv
package bfm_pkg;

   // Decoded class of one control-port request
   typedef enum logic [1:0] {
      ACC_IDLE = 2'd0,
      ACC_RD   = 2'd1,
      ACC_WR   = 2'd2,
      ACC_BAD  = 2'd3
   } acc_kind_e;

   // Number of control registers / read ports (fixed by the block)
   localparam int unsigned CTRL_PORTS = 2;

   // Pack a control word: valid at the top bit, select in the low bits
   function automatic logic [63:0] pack_ctrl(input logic vld,
                                             input logic [7:0] sel,
                                             input int unsigned sel_w,
                                             input int unsigned data_w);
      logic [63:0] w;
      w = '0;
      for (int unsigned i = 0; i < 8; i++) begin
         if (i < sel_w) w[i] = sel[i];
      end
      w[data_w-1] = vld;
      return w;
   endfunction

endpackage

// File: rtl/bfm_flag_mirror.sv
module bfm_flag_mirror #(
   parameter int unsigned N_FLAGS = 16,
   parameter int unsigned IDX_W   = 4
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               upd_valid,
   input  logic [IDX_W-1:0]   upd_idx,
   input  logic               upd_value,
   output logic [N_FLAGS-1:0] flags
);

   generate
      if ((1 << IDX_W) != N_FLAGS) begin : g_bad_idx
         $error("bfm_flag_mirror: N_FLAGS must equal 2**IDX_W");
      end
   endgenerate

   // One storage bit per flag, each with its own decoded enable
   generate
      for (genvar f = 0; f < N_FLAGS; f++) begin : g_flag
         logic hit;
         assign hit = upd_valid && (upd_idx == IDX_W'(f));
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               flags[f] <= 1'b0;
            end else if (hit) begin
               flags[f] <= upd_value;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/bfm_ctrl_file.sv
module bfm_ctrl_file
   import bfm_pkg::*;
#(
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned IDX_W       = 4,
   parameter int unsigned ASPACE_W    = 8,
   parameter int unsigned OFF_W       = 8,
   parameter int unsigned CTRL_ASPACE = 'h6F,
   parameter int unsigned OFF_BASE    = 'h00,
   parameter int unsigned OFF_STRIDE  = 'h08
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           reg_req,
   input  logic                           reg_we,
   input  logic                           reg_priv,
   input  logic [ASPACE_W-1:0]            reg_aspace,
   input  logic [OFF_W-1:0]               reg_offset,
   input  logic [DATA_W-1:0]              reg_wdata,
   output logic [DATA_W-1:0]              reg_rdata,
   output logic                           reg_err,
   output logic [CTRL_PORTS-1:0]          ctrl_valid,
   output logic [CTRL_PORTS*IDX_W-1:0]    ctrl_sel,
   output logic [CTRL_PORTS-1:0]          ctrl_we
);

   localparam int unsigned LAST_OFF = OFF_BASE + (CTRL_PORTS - 1) * OFF_STRIDE;

   generate
      if (LAST_OFF >= (1 << OFF_W)) begin : g_bad_off
         $error("bfm_ctrl_file: register offsets do not fit OFF_W");
      end
      if (CTRL_ASPACE >= (1 << ASPACE_W)) begin : g_bad_asp
         $error("bfm_ctrl_file: CTRL_ASPACE does not fit ASPACE_W");
      end
      if (IDX_W + 1 >= DATA_W) begin : g_bad_w
         $error("bfm_ctrl_file: select and valid bits overlap");
      end
   endgenerate

   logic [CTRL_PORTS-1:0] hit;
   logic                  asp_ok;
   acc_kind_e             acc;

   assign asp_ok = (reg_aspace == ASPACE_W'(CTRL_ASPACE));

   generate
      for (genvar k = 0; k < CTRL_PORTS; k++) begin : g_dec
         assign hit[k] = asp_ok &&
                         (reg_offset == OFF_W'(OFF_BASE + k * OFF_STRIDE));
      end
   endgenerate

   always_comb begin
      if (!reg_req)                  acc = ACC_IDLE;
      else if (!reg_priv || ~|hit)   acc = ACC_BAD;
      else if (reg_we)               acc = ACC_WR;
      else                           acc = ACC_RD;
   end

   // Register storage: only the valid bit and the select field exist
   generate
      for (genvar k = 0; k < CTRL_PORTS; k++) begin : g_reg
         logic             vld_q;
         logic [IDX_W-1:0] sel_q;
         assign ctrl_we[k] = (acc == ACC_WR) && hit[k];
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               vld_q <= 1'b0;
               sel_q <= '0;
            end else if (ctrl_we[k]) begin
               vld_q <= reg_wdata[DATA_W-1];
               sel_q <= reg_wdata[IDX_W-1:0];
            end
         end
         assign ctrl_valid[k]                 = vld_q;
         assign ctrl_sel[k*IDX_W +: IDX_W]    = sel_q;
      end
   endgenerate

   // Read-back mux over the decoded register
   logic [DATA_W-1:0] rd_word;
   always_comb begin
      rd_word = '0;
      for (int k = 0; k < CTRL_PORTS; k++) begin
         if (hit[k]) begin
            rd_word[DATA_W-1]  = ctrl_valid[k];
            rd_word[IDX_W-1:0] = ctrl_sel[k*IDX_W +: IDX_W];
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         reg_rdata <= '0;
         reg_err   <= 1'b0;
      end else begin
         reg_rdata <= (acc == ACC_RD) ? rd_word : '0;
         reg_err   <= (acc == ACC_BAD);
      end
   end

endmodule

// File: rtl/bfm_flag_select.sv
module bfm_flag_select #(
   parameter int unsigned N_FLAGS = 16,
   parameter int unsigned IDX_W   = 4,
   parameter int unsigned DATA_W  = 64
) (
   input  logic               valid,
   input  logic [IDX_W-1:0]   sel,
   input  logic [N_FLAGS-1:0] flags,
   output logic [DATA_W-1:0]  word
);

   logic picked;

   assign picked = flags[sel];

   // Result in bit 0, upper bits always clear; gated by valid
   always_comb begin
      word    = '0;
      word[0] = valid & picked;
   end

endmodule

// File: rtl/barrier_mirror_sel.sv
module barrier_mirror_sel
   import bfm_pkg::*;
#(
   parameter int unsigned N_UNITS     = 2,
   parameter int unsigned N_LINES     = 8,
   parameter int unsigned DATA_W      = 64,
   parameter int unsigned ASPACE_W    = 8,
   parameter int unsigned OFF_W       = 8,
   parameter int unsigned CTRL_ASPACE = 'h6F,
   parameter int unsigned OFF_BASE    = 'h00,
   parameter int unsigned OFF_STRIDE  = 'h08
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                upd_valid,
   input  logic                upd_unit,
   input  logic [2:0]          upd_line,
   input  logic                upd_value,
   input  logic                reg_req,
   input  logic                reg_we,
   input  logic                reg_priv,
   input  logic [ASPACE_W-1:0] reg_aspace,
   input  logic [OFF_W-1:0]    reg_offset,
   input  logic [DATA_W-1:0]   reg_wdata,
   output logic [DATA_W-1:0]   reg_rdata,
   output logic                reg_err,
   output logic [DATA_W-1:0]   rd0_data,
   output logic [DATA_W-1:0]   rd1_data
);

   localparam int unsigned UNIT_W  = $clog2(N_UNITS);
   localparam int unsigned LINE_W  = $clog2(N_LINES);
   localparam int unsigned IDX_W   = UNIT_W + LINE_W;
   localparam int unsigned N_FLAGS = N_UNITS * N_LINES;

   generate
      if (N_UNITS != 2 || N_LINES != 8) begin : g_bad_geom
         $error("barrier_mirror_sel: port widths assume 2 units of 8 lines");
      end
   endgenerate

   logic [N_FLAGS-1:0]               flags;
   logic [CTRL_PORTS-1:0]            ctrl_valid;
   logic [CTRL_PORTS*IDX_W-1:0]      ctrl_sel;
   logic [CTRL_PORTS-1:0]            ctrl_we;
   logic [CTRL_PORTS-1:0][DATA_W-1:0] rd_word;

   bfm_flag_mirror #(
      .N_FLAGS (N_FLAGS),
      .IDX_W   (IDX_W)
   ) u_mirror (
      .clk       (clk),
      .rst_n     (rst_n),
      .upd_valid (upd_valid),
      .upd_idx   ({upd_unit, upd_line}),
      .upd_value (upd_value),
      .flags     (flags)
   );

   bfm_ctrl_file #(
      .DATA_W      (DATA_W),
      .IDX_W       (IDX_W),
      .ASPACE_W    (ASPACE_W),
      .OFF_W       (OFF_W),
      .CTRL_ASPACE (CTRL_ASPACE),
      .OFF_BASE    (OFF_BASE),
      .OFF_STRIDE  (OFF_STRIDE)
   ) u_ctrl (
      .clk        (clk),
      .rst_n      (rst_n),
      .reg_req    (reg_req),
      .reg_we     (reg_we),
      .reg_priv   (reg_priv),
      .reg_aspace (reg_aspace),
      .reg_offset (reg_offset),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_err    (reg_err),
      .ctrl_valid (ctrl_valid),
      .ctrl_sel   (ctrl_sel),
      .ctrl_we    (ctrl_we)
   );

   generate
      for (genvar k = 0; k < CTRL_PORTS; k++) begin : g_port
         bfm_flag_select #(
            .N_FLAGS (N_FLAGS),
            .IDX_W   (IDX_W),
            .DATA_W  (DATA_W)
         ) u_sel (
            .valid (ctrl_valid[k]),
            .sel   (ctrl_sel[k*IDX_W +: IDX_W]),
            .flags (flags),
            .word  (rd_word[k])
         );
      end
   endgenerate

   assign rd0_data = rd_word[0];
   assign rd1_data = rd_word[1];

endmodule

// File: rtl/bfm_checker.sv
module bfm_checker #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned IDX_W  = 4
) (
   input logic                clk,
   input logic                rst_n,
   input logic                upd_valid,
   input logic                upd_unit,
   input logic [2:0]          upd_line,
   input logic                upd_value,
   input logic                reg_req,
   input logic                reg_we,
   input logic                reg_priv,
   input logic [DATA_W-1:0]   reg_rdata,
   input logic                reg_err,
   input logic [DATA_W-1:0]   rd0_data,
   input logic [DATA_W-1:0]   rd1_data,
   input logic [1:0]          ctrl_valid,
   input logic [2*IDX_W-1:0]  ctrl_sel,
   input logic [1:0]          ctrl_we
);

   AST_INVALID_PORT0_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_valid[0] |-> rd0_data == '0); // R4

   AST_INVALID_PORT1_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_valid[1] |-> rd1_data == '0); // R4

   AST_PORT_UPPER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      rd0_data[DATA_W-1:1] == '0 && rd1_data[DATA_W-1:1] == '0); // R5

   AST_UPDATE_VISIBLE: assert property (@(posedge clk) disable iff (!rst_n)
      (upd_valid && ctrl_valid[0] && !ctrl_we[0] &&
       ctrl_sel[IDX_W-1:0] == {upd_unit, upd_line})
      |=> rd0_data[0] == $past(upd_value)); // R7

   AST_UNPRIV_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_req && !reg_priv) |=> $stable(ctrl_valid) && $stable(ctrl_sel)); // R9

   AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_req |=> !reg_err); // R10

   AST_RDATA_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!reg_req || reg_we) |=> reg_rdata == '0); // R6

endmodule

bind barrier_mirror_sel bfm_checker #(
   .DATA_W (DATA_W),
   .IDX_W  (IDX_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .upd_valid  (upd_valid),
   .upd_unit   (upd_unit),
   .upd_line   (upd_line),
   .upd_value  (upd_value),
   .reg_req    (reg_req),
   .reg_we     (reg_we),
   .reg_priv   (reg_priv),
   .reg_rdata  (reg_rdata),
   .reg_err    (reg_err),
   .rd0_data   (rd0_data),
   .rd1_data   (rd1_data),
   .ctrl_valid (ctrl_valid),
   .ctrl_sel   (ctrl_sel),
   .ctrl_we    (ctrl_we)
);

// File: tb/barrier_mirror_sel_tb.sv
`timescale 1ns/1ps
module barrier_mirror_sel_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        upd_valid = 1'b0;
   logic        upd_unit = 1'b0;
   logic [2:0]  upd_line = '0;
   logic        upd_value = 1'b0;
   logic        reg_req = 1'b0;
   logic        reg_we = 1'b0;
   logic        reg_priv = 1'b0;
   logic [7:0]  reg_aspace = '0;
   logic [7:0]  reg_offset = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        reg_err;
   logic [63:0] rd0_data;
   logic [63:0] rd1_data;

   int n_chk = 0;
   int n_fail = 0;

   always #2 clk = ~clk;

   barrier_mirror_sel u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .upd_valid  (upd_valid),
      .upd_unit   (upd_unit),
      .upd_line   (upd_line),
      .upd_value  (upd_value),
      .reg_req    (reg_req),
      .reg_we     (reg_we),
      .reg_priv   (reg_priv),
      .reg_aspace (reg_aspace),
      .reg_offset (reg_offset),
      .reg_wdata  (reg_wdata),
      .reg_rdata  (reg_rdata),
      .reg_err    (reg_err),
      .rd0_data   (rd0_data),
      .rd1_data   (rd1_data)
   );

   // ---------------- behavioural reference model ----------------
   localparam logic [63:0] FIELD_MASK = 64'h8000_0000_0000_000F;
   bit          m_flag [16];
   logic [63:0] m_ctrl [2];
   logic [63:0] m_rdata;
   logic        m_err;

   function automatic int reg_slot(input logic [7:0] asp, input logic [7:0] off);
      if (asp != 8'h6F) return -1;
      if (off == 8'h00) return 0;
      if (off == 8'h08) return 1;
      return -1;
   endfunction

   function automatic logic [63:0] port_val(input int p);
      if (!m_ctrl[p][63]) return 64'd0;
      return {63'd0, m_flag[m_ctrl[p][3:0]]};
   endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         foreach (m_flag[i]) m_flag[i] = 1'b0;
         m_ctrl[0] = '0;
         m_ctrl[1] = '0;
         m_rdata = '0;
         m_err = 1'b0;
      end else begin
         int slot;
         slot = reg_slot(reg_aspace, reg_offset);
         m_rdata = '0;
         m_err = 1'b0;
         if (reg_req) begin
            if (!reg_priv || slot < 0) m_err = 1'b1;
            else if (reg_we) m_ctrl[slot] = reg_wdata & FIELD_MASK;
            else m_rdata = m_ctrl[slot];
         end
         if (upd_valid) m_flag[{upd_unit, upd_line}] = upd_value;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Compare every clock, mid-cycle
   always @(negedge clk) begin
      if (rst_n) begin
         chk("R5 port0 vs model", rd0_data, port_val(0));
         chk("R5 port1 vs model", rd1_data, port_val(1));
         chk("R6 reg_rdata vs model", reg_rdata, m_rdata);
         chk("R10 reg_err vs model", {63'd0, reg_err}, {63'd0, m_err});
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic idle_in();
      reg_req = 1'b0;
      reg_we = 1'b0;
      upd_valid = 1'b0;
   endtask

   task automatic acc(input logic we, input logic priv, input logic [7:0] asp,
                      input logic [7:0] off, input logic [63:0] d);
      reg_req = 1'b1;
      reg_we = we;
      reg_priv = priv;
      reg_aspace = asp;
      reg_offset = off;
      reg_wdata = d;
      step();
      idle_in();
   endtask

   task automatic upd(input int idx, input logic v);
      upd_valid = 1'b1;
      upd_unit = idx[3];
      upd_line = idx[2:0];
      upd_value = v;
      step();
      idle_in();
   endtask

   localparam logic [63:0] VLD = 64'h8000_0000_0000_0000;
   bit ref_flag [16];

   initial begin
      #(4 * 60000);
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      idle_in();
      repeat (4) step();
      rst_n = 1'b1;
      step();

      // R1: reset state
      chk("R1 port0 after reset", rd0_data, 64'd0);
      chk("R1 port1 after reset", rd1_data, 64'd0);
      chk("R1 reg_err after reset", {63'd0, reg_err}, 64'd0);
      acc(1'b0, 1'b1, 8'h6F, 8'h00, '0);
      chk("R1 ctrl0 reads zero", reg_rdata, 64'd0);
      acc(1'b0, 1'b1, 8'h6F, 8'h08, '0);
      chk("R1 ctrl1 reads zero", reg_rdata, 64'd0);

      // Load flags: unit0 line3, unit1 line5, unit1 line0 set
      upd(3, 1'b1); upd(13, 1'b1); upd(8, 1'b1);
      ref_flag[3] = 1; ref_flag[13] = 1; ref_flag[8] = 1;

      // R4: invalid select returns zero even pointing at a set flag
      acc(1'b1, 1'b1, 8'h6F, 8'h00, 64'h0000_0000_0000_0003);
      chk("R4 port0 invalid returns 0", rd0_data, 64'd0);

      // R3/R5: valid select on port 0 only
      acc(1'b1, 1'b1, 8'h6F, 8'h00, VLD | 64'd3);
      chk("R5 port0 picks unit0 line3", rd0_data, 64'd1);
      chk("R3 port1 untouched by ctrl0", rd1_data, 64'd0);
      acc(1'b1, 1'b1, 8'h6F, 8'h08, VLD | 64'd13);
      chk("R3 port1 picks unit1 line5", rd1_data, 64'd1);
      acc(1'b1, 1'b1, 8'h6F, 8'h08, VLD | 64'd5);
      chk("R5 unit bit separates flags", rd1_data, 64'd0);

      // R6: junk bits dropped on write, fields read back
      acc(1'b1, 1'b1, 8'h6F, 8'h00, 64'hFFFF_FFFF_FFFF_FFF3);
      acc(1'b0, 1'b1, 8'h6F, 8'h00, '0);
      chk("R6 ctrl0 readback masked", reg_rdata, VLD | 64'd3);
      step();
      chk("R6 rdata clears after read", reg_rdata, 64'd0);

      // R2: neighbour update leaves selected flag alone
      upd(4, 1'b1); ref_flag[4] = 1;
      upd(2, 1'b1); ref_flag[2] = 1;
      chk("R2 neighbours keep port0", rd0_data, 64'd1);

      // R7: same-cycle update of the selected flag
      upd_valid = 1'b1; upd_unit = 1'b0; upd_line = 3'd3; upd_value = 1'b0;
      #1;
      chk("R7 old value in update cycle", rd0_data, 64'd1);
      step();
      idle_in();
      ref_flag[3] = 0;
      chk("R7 new value next cycle", rd0_data, 64'd0);

      // R8: wrong address space / offsets
      acc(1'b1, 1'b1, 8'h6E, 8'h00, VLD | 64'd8);
      chk("R8 bad aspace raises err", {63'd0, reg_err}, 64'd1);
      acc(1'b1, 1'b1, 8'h6F, 8'h10, VLD | 64'd8);
      chk("R8 bad offset raises err", {63'd0, reg_err}, 64'd1);
      acc(1'b1, 1'b1, 8'h6F, 8'h04, VLD | 64'd8);
      chk("R8 odd offset raises err", {63'd0, reg_err}, 64'd1);
      step();
      chk("R10 err is one pulse", {63'd0, reg_err}, 64'd0);
      acc(1'b0, 1'b1, 8'h6F, 8'h00, '0);
      chk("R8 ctrl0 unchanged", reg_rdata, VLD | 64'd3);

      // R9: unprivileged write and read
      acc(1'b1, 1'b0, 8'h6F, 8'h08, VLD | 64'd8);
      chk("R9 unpriv write err", {63'd0, reg_err}, 64'd1);
      chk("R9 unpriv write no effect on port1", rd1_data, 64'd0);
      acc(1'b0, 1'b0, 8'h6F, 8'h08, '0);
      chk("R9 unpriv read err", {63'd0, reg_err}, 64'd1);
      chk("R9 unpriv read gives 0", reg_rdata, 64'd0);
      acc(1'b0, 1'b1, 8'h6F, 8'h08, '0);
      chk("R9 ctrl1 unchanged", reg_rdata, VLD | 64'd5);
      chk("R10 accepted access no err", {63'd0, reg_err}, 64'd0);

      // R5/R2: distinct pattern over all flags, walk port0 select
      for (int i = 0; i < 16; i++) begin
         ref_flag[i] = ((i * 7 + 3) % 5) < 2;
         upd(i, ref_flag[i]);
      end
      for (int i = 0; i < 16; i++) begin
         acc(1'b1, 1'b1, 8'h6F, 8'h00, VLD | 64'(i));
         chk("R5 walk port0 select", rd0_data, {63'd0, ref_flag[i]});
      end

      // Concurrent update and register write
      upd_valid = 1'b1; upd_unit = 1'b1; upd_line = 3'd7; upd_value = ~ref_flag[15];
      acc(1'b1, 1'b1, 8'h6F, 8'h08, VLD | 64'd15);
      ref_flag[15] = ~ref_flag[15];
      chk("R2 concurrent update seen on port1", rd1_data, {63'd0, ref_flag[15]});

      repeat (3) step();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule